// File: doc/BRIEF.md
# Dual-Modulus PLL Divider Word Programmer

This block programs a dual-modulus prescaler frequency synthesizer from a channel request. A host presents an unsigned transmit frequency in kHz together with a one-cycle `start` strobe. The block derives three divider settings with a bit-serial divider. The reference divider is the constant 2560. The main divider is the frequency over 320, rounded down. The swallow counter is the frequency over 5, minus 64 times the main divider. The block then sends a 32-bit word to the synthesizer over a three-wire serial interface made of a clock, a data line and an active-high enable.

The word carries the 14-bit reference value, then the 10-bit main value, then the 7-bit swallow value, each with its most significant bit first. A single `1` bit closes the word and tells the synthesizer to latch it. A request is refused when the frequency is not on the 5 kHz raster, or when the main divider does not fit in its field. A refused request raises `err` and leaves the serial lines idle. Every request, whether accepted or refused, ends with a one-cycle `done` pulse.

Top module: `pll_word_prog`

## Requirements
- R1: Bits 31 down to 18 of the serial word, which are the first 14 bits sent, carry the reference value 2560 with the most significant bit first.
- R2: Bits 17 down to 8 of the word carry floor(freq_khz / 320) with the most significant bit first.
- R3: Bits 7 down to 1 of the word carry freq_khz / 5 − 64·floor(freq_khz / 320) with the most significant bit first.
- R4: Bit 0, the last bit sent, is always 1, and an accepted request sends exactly 32 bits.
- R5: `ser_data` changes only when `ser_clk` falls or `ser_en` changes. It holds steady while `ser_clk` is high, and `ser_clk` stays low while `ser_en` is low.
- R6: `ser_en` rises while `ser_clk` is low. The first rising edge of `ser_clk` comes SCK_HALF system cycles later, and the rising edges that follow are spaced 2·SCK_HALF cycles apart. `ser_en` falls 2·SCK_HALF cycles after the last rising edge.
- R7: A frequency that is not a multiple of 5 raises `err` at `done`. In that case `ser_en` and `ser_clk` never go high.
- R8: A frequency whose main divider exceeds 1023 (freq_khz ≥ 327680) raises `err` at `done`, and nothing is sent.
- R9: A `start` that arrives while `busy` is high is ignored. The word being sent does not change, and no second request follows.
- R10: `busy` is high from the cycle after an accepted `start` until `done`. `done` is high for exactly one cycle, and `busy` is low in that cycle.
- R11: During reset and just after it, `busy`, `done`, `err`, `ser_clk`, `ser_data` and `ser_en` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request strobe, sampled when idle |
| freq_khz | input | FREQ_W | Requested frequency in kHz, sampled with `start` |
| busy | output | 1 | Request in progress |
| done | output | 1 | One-cycle end-of-request pulse |
| err | output | 1 | Last request refused; valid from `done` until the next start |
| ser_clk | output | 1 | Serial clock to the synthesizer |
| ser_data | output | 1 | Serial data, stable while `ser_clk` is high |
| ser_en | output | 1 | Active-high frame enable |

## Verification
The embedded properties assume that `freq_khz` is read only in the cycle in which `start` is accepted. They also assume that `start` lasts a single cycle. The stimulus drives `start` for one cycle at a time and changes `freq_khz` right after it is taken, so any late capture shows up as a wrong word. The random frequencies cover the whole 20-bit input range. They are spread over words on the 5 kHz raster, values just off that raster, and values past the main-divider limit. Directed values cover zero, the largest legal word, the first frequency that overflows, and a strobe injected in the middle of a transfer.

// File: rtl/pll_prog_pkg.sv
package pll_prog_pkg;

   typedef enum logic [1:0] {
      TOP_IDLE,
      TOP_DIV,
      TOP_CHECK,
      TOP_SEND
   } top_st_e;

   typedef enum logic [1:0] {
      SER_IDLE,
      SER_BIT,
      SER_TRAIL
   } ser_st_e;

   function automatic bit is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/pll_seq_div.sv
module pll_seq_div
   import pll_prog_pkg::*;
#(
   parameter int unsigned W       = 20,
   parameter int unsigned DIVISOR = 5,
   localparam int unsigned RW     = $clog2(DIVISOR) + 1
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          go,
   input  logic [W-1:0]  dividend,
   output logic          vld,
   output logic [W-1:0]  quot,
   output logic [RW-1:0] rem
);

   localparam int unsigned CW = $clog2(W + 1);

   if (DIVISOR < 2) begin : bad_divisor
      $error("pll_seq_div: DIVISOR must be at least 2");
   end
   if (W < 2) begin : bad_width
      $error("pll_seq_div: W must be at least 2");
   end

   if (is_pow2(DIVISOR)) begin : g_shift
      localparam int unsigned LG = $clog2(DIVISOR);
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            vld  <= 1'b0;
            quot <= '0;
            rem  <= '0;
         end else begin
            vld <= go;
            if (go) begin
               quot <= dividend >> LG;
               rem  <= RW'(dividend & W'(DIVISOR - 1));
            end
         end
      end
   end else begin : g_restore
      logic [W-1:0]  q_sh;
      logic [W-1:0]  src;
      logic [RW-1:0] rem_r;
      logic [RW-1:0] trial;
      logic [CW-1:0] cnt;
      logic          run;
      logic          ge;

      always_comb begin
         trial = {rem_r[RW-2:0], q_sh[W-1]};
         ge    = (trial >= RW'(DIVISOR));
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            q_sh  <= '0;
            src   <= '0;
            rem_r <= '0;
            cnt   <= '0;
            run   <= 1'b0;
            vld   <= 1'b0;
         end else begin
            vld <= 1'b0;
            if (go) begin
               q_sh  <= dividend;
               src   <= dividend;
               rem_r <= '0;
               cnt   <= '0;
               run   <= 1'b1;
            end else if (run) begin
               rem_r <= ge ? (trial - RW'(DIVISOR)) : trial;
               q_sh  <= {q_sh[W-2:0], ge};
               cnt   <= cnt + 1'b1;
               if (cnt == CW'(W - 1)) begin
                  run <= 1'b0;
                  vld <= 1'b1;
               end
            end
         end
      end

      assign quot = q_sh;
      assign rem  = rem_r;

      // R2
      div_identity_chk: assert property (@(posedge clk) disable iff (!rst_n)
         vld |-> (({{RW{1'b0}}, quot} * (W + RW)'(DIVISOR)) + (W + RW)'(rem)
                  == {{RW{1'b0}}, src}));

      // R3
      rem_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
         vld |-> (rem < RW'(DIVISOR)));
   end

endmodule

// File: rtl/pll_frame_ser.sv
module pll_frame_ser
   import pll_prog_pkg::*;
#(
   parameter int unsigned FRAME_W  = 32,
   parameter int unsigned SCK_HALF = 2
)(
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic [FRAME_W-1:0] frame,
   output logic               ser_clk,
   output logic               ser_data,
   output logic               ser_en,
   output logic               fin
);

   localparam int unsigned BW  = $clog2(FRAME_W);
   localparam int unsigned HCW = $clog2(SCK_HALF + 1);

   if (FRAME_W < 2) begin : bad_frame
      $error("pll_frame_ser: FRAME_W must be at least 2");
   end
   if (SCK_HALF < 1) begin : bad_half
      $error("pll_frame_ser: SCK_HALF must be at least 1");
   end

   ser_st_e            st;
   logic [FRAME_W-1:0] sh;
   logic [BW-1:0]      bidx;
   logic [HCW-1:0]     hc;
   logic               half_end;

   assign half_end = (hc == HCW'(SCK_HALF - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= SER_IDLE;
         sh      <= '0;
         bidx    <= '0;
         hc      <= '0;
         ser_clk <= 1'b0;
         ser_en  <= 1'b0;
         fin     <= 1'b0;
      end else begin
         fin <= 1'b0;
         unique case (st)
            SER_IDLE: begin
               if (load) begin
                  sh      <= frame;
                  ser_en  <= 1'b1;
                  ser_clk <= 1'b0;
                  hc      <= '0;
                  bidx    <= BW'(FRAME_W - 1);
                  st      <= SER_BIT;
               end
            end
            SER_BIT: begin
               if (half_end) begin
                  hc <= '0;
                  if (!ser_clk) begin
                     ser_clk <= 1'b1;
                  end else begin
                     ser_clk <= 1'b0;
                     if (bidx == '0) begin
                        st <= SER_TRAIL;
                     end else begin
                        bidx <= bidx - 1'b1;
                        sh   <= {sh[FRAME_W-2:0], 1'b0};
                     end
                  end
               end else begin
                  hc <= hc + 1'b1;
               end
            end
            SER_TRAIL: begin
               if (half_end) begin
                  hc     <= '0;
                  ser_en <= 1'b0;
                  sh     <= '0;
                  fin    <= 1'b1;
                  st     <= SER_IDLE;
               end else begin
                  hc <= hc + 1'b1;
               end
            end
            default: st <= SER_IDLE;
         endcase
      end
   end

   assign ser_data = sh[FRAME_W-1];

   // R5
   data_hold_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ser_clk && $past(ser_clk)) |-> $stable(ser_data));

   // R5
   data_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(ser_data) |-> ($fell(ser_clk) || $rose(ser_en) || $fell(ser_en)));

   // R5
   clk_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ser_en |-> !ser_clk);

   // R6
   en_lead_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ser_en) |-> !ser_clk);

   // R6
   en_trail_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ser_en) |-> (!$past(ser_clk) && fin));

endmodule

// File: rtl/pll_word_prog.sv
module pll_word_prog
   import pll_prog_pkg::*;
#(
   parameter int unsigned FREQ_W   = 20,
   parameter int unsigned CH_KHZ   = 5,
   parameter int unsigned MOD      = 64,
   parameter int unsigned R_VAL    = 2560,
   parameter int unsigned R_W      = 14,
   parameter int unsigned N_W      = 10,
   parameter int unsigned A_W      = 7,
   parameter int unsigned SCK_HALF = 2
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [FREQ_W-1:0] freq_khz,
   output logic              busy,
   output logic              done,
   output logic              err,
   output logic              ser_clk,
   output logic              ser_data,
   output logic              ser_en
);

   localparam int unsigned FRAME_W = R_W + N_W + A_W + 1;
   localparam int unsigned LG_MOD  = $clog2(MOD);
   localparam int unsigned DRW     = $clog2(CH_KHZ) + 1;

   if (!is_pow2(MOD)) begin : bad_mod
      $error("pll_word_prog: MOD must be a power of two");
   end
   if (MOD > (1 << A_W)) begin : bad_a_w
      $error("pll_word_prog: A_W too narrow for MOD");
   end
   if (R_VAL >= (1 << R_W)) begin : bad_r
      $error("pll_word_prog: R_VAL does not fit R_W");
   end
   if (FREQ_W > 30 || N_W > 30) begin : bad_widths
      $error("pll_word_prog: FREQ_W and N_W must not exceed 30");
   end

   top_st_e            st;
   logic [FREQ_W-1:0]  freq_q;
   logic               div_go;
   logic               div_vld;
   logic [FREQ_W-1:0]  quot;
   logic [DRW-1:0]     rem;
   logic [FREQ_W-1:0]  n_full;
   logic [FREQ_W-1:0]  a_full;
   logic               n_ovf;
   logic               a_ovf;
   logic               off_grid;
   logic [N_W-1:0]     n_q;
   logic [A_W-1:0]     a_q;
   logic               bad_q;
   logic               load;
   logic               fin;
   logic [FRAME_W-1:0] frame;

   pll_seq_div #(
      .W       (FREQ_W),
      .DIVISOR (CH_KHZ)
   ) div_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .go       (div_go),
      .dividend (freq_q),
      .vld      (div_vld),
      .quot     (quot),
      .rem      (rem)
   );

   always_comb begin
      n_full   = quot >> LG_MOD;
      a_full   = quot - (n_full << LG_MOD);
      n_ovf    = (32'(n_full) >= (32'd1 << N_W));
      a_ovf    = (32'(a_full) >= (32'd1 << A_W));
      off_grid = (rem != '0);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st     <= TOP_IDLE;
         freq_q <= '0;
         div_go <= 1'b0;
         load   <= 1'b0;
         done   <= 1'b0;
         err    <= 1'b0;
         n_q    <= '0;
         a_q    <= '0;
         bad_q  <= 1'b0;
      end else begin
         div_go <= 1'b0;
         load   <= 1'b0;
         done   <= 1'b0;
         unique case (st)
            TOP_IDLE: begin
               if (start) begin
                  freq_q <= freq_khz;
                  div_go <= 1'b1;
                  err    <= 1'b0;
                  st     <= TOP_DIV;
               end
            end
            TOP_DIV: begin
               if (div_vld) begin
                  n_q   <= N_W'(n_full);
                  a_q   <= A_W'(a_full);
                  bad_q <= off_grid | n_ovf | a_ovf;
                  st    <= TOP_CHECK;
               end
            end
            TOP_CHECK: begin
               if (bad_q) begin
                  err  <= 1'b1;
                  done <= 1'b1;
                  st   <= TOP_IDLE;
               end else begin
                  load <= 1'b1;
                  st   <= TOP_SEND;
               end
            end
            TOP_SEND: begin
               if (fin) begin
                  done <= 1'b1;
                  st   <= TOP_IDLE;
               end
            end
            default: st <= TOP_IDLE;
         endcase
      end
   end

   assign busy  = (st != TOP_IDLE);
   assign frame = {R_W'(R_VAL), n_q, a_q, 1'b1};

   pll_frame_ser #(
      .FRAME_W  (FRAME_W),
      .SCK_HALF (SCK_HALF)
   ) ser_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (load),
      .frame    (frame),
      .ser_clk  (ser_clk),
      .ser_data (ser_data),
      .ser_en   (ser_en),
      .fin      (fin)
   );

   // R10
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R10
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   // R9
   busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !done) |=> $stable(freq_q));

   // R7
   err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> (!ser_en && !ser_clk));

   // R4
   load_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
      load |-> (frame[0] && !bad_q));

endmodule

// File: tb/pll_word_prog_tb_top.sv
module pll_word_prog_tb_top;

   localparam int H = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [19:0] freq_khz = '0;
   logic        busy, done, err, ser_clk, ser_data, ser_en;

   always #2 clk = ~clk;

   pll_word_prog dut_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .freq_khz (freq_khz),
      .busy     (busy),
      .done     (done),
      .err      (err),
      .ser_clk  (ser_clk),
      .ser_data (ser_data),
      .ser_en   (ser_en)
   );

   int n_chk = 0;
   int n_fail = 0;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // serial line monitor
   logic        p_sck = 1'b0, p_en = 1'b0, p_data = 1'b0;
   logic        first_rise = 1'b0;
   longint      cyc = 0, en_rise_c = 0, last_rise_c = 0;
   int          nbits = 0, n_en_rise = 0, tim_bad = 0, n_done = 0;
   logic [31:0] cap = '0;

   always @(negedge clk) begin
      cyc++;
      if (ser_en && !p_en) begin
         n_en_rise++;
         en_rise_c  = cyc;
         first_rise = 1'b1;
         if (ser_clk) tim_bad++;
      end
      if (ser_clk && !p_sck) begin
         if (!ser_en) tim_bad++;
         cap = {cap[30:0], ser_data};
         nbits++;
         if (first_rise) begin
            if (cyc - en_rise_c != H) tim_bad++;
         end else if (cyc - last_rise_c != 2 * H) begin
            tim_bad++;
         end
         first_rise  = 1'b0;
         last_rise_c = cyc;
      end
      if (ser_clk && p_sck && ser_data != p_data) tim_bad++;
      if (!ser_en && p_en && (cyc - last_rise_c != 2 * H)) tim_bad++;
      if (done) n_done++;
      p_sck  = ser_clk;
      p_en   = ser_en;
      p_data = ser_data;
   end

   function automatic bit exp_err(input int f);
      return (f % 5 != 0) || (f / 320 > 1023);
   endfunction

   function automatic int exp_n(input int f);
      return f / 320;
   endfunction

   function automatic int exp_a(input int f);
      return f / 5 - 64 * (f / 320);
   endfunction

   task automatic run_req(input int f, input int inj);
      int  waited;
      bit  e;
      e = exp_err(f);
      nbits = 0; n_en_rise = 0; tim_bad = 0; n_done = 0; cap = '0;
      @(negedge clk);
      start = 1'b1;
      freq_khz = 20'(f);
      @(negedge clk);
      start = 1'b0;
      freq_khz = 20'(f) ^ 20'h0A5A5;
      chk(busy == 1'b1, "R10", "busy after start", busy, 1);
      waited = 0;
      while (!done && waited < 5000) begin
         if (waited == inj) begin
            start = 1'b1;
            freq_khz = 20'(f) ^ 20'h00140;
         end else begin
            start = 1'b0;
         end
         @(negedge clk);
         waited++;
      end
      start = 1'b0;
      chk(waited < 5000, "R10", "done reached", waited, 0);
      chk(err == e, e ? ((f % 5 != 0) ? "R7" : "R8") : "R7", "err at done", err, e);
      chk(busy == 1'b0, "R10", "busy low with done", busy, 0);
      @(negedge clk);
      chk(done == 1'b0, "R10", "done single cycle", done, 0);
      repeat (4 * H + 30) @(negedge clk);
      chk(busy == 1'b0, "R9", "no queued request", busy, 0);
      chk(n_done == 1, "R9", "done count", n_done, 1);
      if (e) begin
         chk(nbits == 0 && n_en_rise == 0, (f % 5 != 0) ? "R7" : "R8",
             "no serial activity", nbits + n_en_rise, 0);
      end else begin
         chk(nbits == 32, "R4", "bit count", nbits, 32);
         chk(n_en_rise == 1, "R6", "enable pulses", n_en_rise, 1);
         chk(cap[31:18] == 14'd2560, "R1", "reference field", cap[31:18], 2560);
         chk(cap[17:8] == 10'(exp_n(f)), "R2", "main field", cap[17:8], exp_n(f));
         chk(cap[7:1] == 7'(exp_a(f)), "R3", "swallow field", cap[7:1], exp_a(f));
         chk(cap[0] == 1'b1, "R4", "control bit", cap[0], 1);
         chk(tim_bad == 0, "R5", "edge timing R6", tim_bad, 0);
      end
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      int f;
      int mode;
      void'($urandom(32'd7321));
      repeat (3) @(negedge clk);
      chk({busy, done, err, ser_clk, ser_data, ser_en} == 6'b0, "R11",
          "outputs in reset", {busy, done, err, ser_clk, ser_data, ser_en}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk({busy, done, err, ser_clk, ser_data, ser_en} == 6'b0, "R11",
          "outputs after reset", {busy, done, err, ser_clk, ser_data, ser_en}, 0);

      // directed corners
      run_req(0, -1);
      run_req(327675, -1);
      run_req(327680, -1);
      run_req(470000, -1);
      run_req(450005, -1);
      run_req(7, -1);
      run_req(160005, 3);
      run_req(204800, 60);
      run_req(1048575, 2);

      // constrained random
      for (int i = 0; i < 40; i++) begin
         mode = int'($urandom % 4);
         case (mode)
            0: f = 5 * (64 * int'($urandom % 1024) + int'($urandom % 64));
            1: f = 5 * (64 * int'($urandom % 1024) + int'($urandom % 64))
                   + 1 + int'($urandom % 4);
            2: f = 327680 + int'($urandom % 720895);
            default: f = int'($urandom % 1048576);
         endcase
         run_req(f, ($urandom % 2 == 0) ? int'($urandom % 120) : -1);
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule